// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves the control-transfer class of a 64-bit packet-filter style virtual machine for one decoded instruction. It takes the 4-bit operation code, the source selector, both operand register values, the 32-bit immediate, the 16-bit offset, the 8-bit register-number field and the current program counter. From these it produces a taken flag, the next program counter, a call strobe, an exit strobe and an illegal-operation flag.

The program counter counts 64-bit instruction slots. A taken branch lands at the slot after the current one plus a signed displacement. Conditional branches and the unconditional jump take this displacement from the 16-bit offset. A call takes it from the 32-bit immediate. Call stack handling and the invocation of helper routines belong to the surrounding pipeline.

The parameter `REG_OUT` chooses between a registered result, one cycle after `in_valid`, and a combinational result in the same cycle. The parameter `STRICT_EXIT` chooses whether a malformed exit is flagged.

Top module: `br_eval_unit`

## Requirements
- R1: The second comparand is `src_val` when `src_sel` is 1. When `src_sel` is 0 it is `imm` sign-extended to 64 bits, and `src_val` is then ignored.
- R2: Code 1 is taken when dst equals the comparand. Code 5 is taken when they differ.
- R3: Unsigned 64-bit compares of dst against the comparand: code 2 (greater), code 3 (greater or equal), code 10 (less), code 11 (less or equal).
- R4: Signed two's-complement compares: code 6 (greater), code 7 (greater or equal), code 12 (less), code 13 (less or equal).
- R5: Code 4 is taken when the bitwise AND of dst and the comparand is nonzero.
- R6: Code 0 is always taken, whatever the operand values.
- R7: On a taken branch, `next_pc` = pc + 1 + disp, modulo 2^PC_W. Otherwise `next_pc` = pc + 1. For codes 0 to 7 and 10 to 13, disp is the sign-extended 16-bit offset.
- R8: Code 8 (call) is taken and raises `out_call`. Its disp is the sign-extended 32-bit immediate, and both register values are ignored.
- R9: Code 9 (exit) raises `out_exit` with taken low and `next_pc` = pc + 1. With `STRICT_EXIT`=1, a nonzero `src_sel`, `regs`, `offset` or `imm` makes it illegal instead, with no exit strobe.
- R10: Codes 14 and 15 raise `out_illegal`, are never taken, and give `next_pc` = pc + 1.
- R11: With `REG_OUT`=1, results appear one cycle after `in_valid` with `out_valid` high. While `out_valid` is low, taken, call, exit and illegal are all low.
- R12: During and right after reset, `out_valid`, `out_taken`, `out_call`, `out_exit` and `out_illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| op_code | input | 4 | Operation code |
| src_sel | input | 1 | 1: register comparand, 0: immediate |
| dst_val | input | XLEN | Destination register value |
| src_val | input | XLEN | Source register value |
| imm | input | IMM_W | Signed immediate |
| offset | input | OFF_W | Signed branch offset |
| regs | input | 8 | Raw register-number field (exit check) |
| pc | input | PC_W | Current slot address |
| out_valid | output | 1 | Result valid |
| out_taken | output | 1 | Transfer taken |
| out_next_pc | output | PC_W | Next slot address |
| out_call | output | 1 | Call strobe |
| out_exit | output | 1 | Exit strobe |
| out_illegal | output | 1 | Undefined or malformed operation |

## Verification
The bench builds the unit with its defaults: XLEN=64, IMM_W=32, OFF_W=16, PC_W=32, REG_OUT=1 and STRICT_EXIT=1. This makes the one-cycle latency, the malformed-exit path and 32-bit program-counter wraparound observable. The 64-bit operand width brings within reach the cases where signed and unsigned orderings disagree, such as the top bit set against a small positive value. Immediate sign extension across the upper word can also be exercised.

// File: rtl/br_pkg.sv
package br_pkg;
   typedef enum logic [3:0] {
      BR_ALWAYS = 4'h0, BR_EQ   = 4'h1, BR_UGT = 4'h2, BR_UGE = 4'h3,
      BR_ANY    = 4'h4, BR_NE   = 4'h5, BR_SGT = 4'h6, BR_SGE = 4'h7,
      BR_CALL   = 4'h8, BR_EXIT = 4'h9, BR_ULT = 4'hA, BR_ULE = 4'hB,
      BR_SLT    = 4'hC, BR_SLE  = 4'hD, BR_BADE = 4'hE, BR_BADF = 4'hF
   } br_op_e;
endpackage

// File: rtl/br_cmp.sv
module br_cmp
   import br_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [3:0]      op,
   input  logic [XLEN-1:0] lhs,
   input  logic [XLEN-1:0] rhs,
   output logic            hit
);
   logic eq, ult, slt;

   assign eq  = (lhs == rhs);
   assign ult = (lhs < rhs);
   assign slt = ($signed(lhs) < $signed(rhs));

   always_comb begin
      unique case (br_op_e'(op))
         BR_EQ:   hit = eq;
         BR_NE:   hit = !eq;
         BR_UGT:  hit = !ult && !eq;
         BR_UGE:  hit = !ult;
         BR_ULT:  hit = ult;
         BR_ULE:  hit = ult || eq;
         BR_SGT:  hit = !slt && !eq;
         BR_SGE:  hit = !slt;
         BR_SLT:  hit = slt;
         BR_SLE:  hit = slt || eq;
         BR_ANY:  hit = |(lhs & rhs);
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/br_target.sv
module br_target #(
   parameter int PC_W   = 32,
   parameter int DISP_W = 32
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [DISP_W-1:0] disp,
   output logic [PC_W-1:0]   seq_pc,
   output logic [PC_W-1:0]   jmp_pc
);
   localparam int SUM_W = ((PC_W > DISP_W) ? PC_W : DISP_W) + 1;

   logic [SUM_W-1:0] disp_x, pc_x, sum;

   assign disp_x = SUM_W'($signed(disp));
   assign pc_x   = SUM_W'(pc);
   assign sum    = pc_x + disp_x + SUM_W'(1);
   assign seq_pc = pc + PC_W'(1);
   assign jmp_pc = sum[PC_W-1:0];
endmodule

// File: rtl/br_eval_unit.sv
module br_eval_unit
   import br_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter int IMM_W       = 32,
   parameter int OFF_W       = 16,
   parameter int PC_W        = 32,
   parameter bit REG_OUT     = 1'b1,
   parameter bit STRICT_EXIT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [3:0]       op_code,
   input  logic             src_sel,
   input  logic [XLEN-1:0]  dst_val,
   input  logic [XLEN-1:0]  src_val,
   input  logic [IMM_W-1:0] imm,
   input  logic [OFF_W-1:0] offset,
   input  logic [7:0]       regs,
   input  logic [PC_W-1:0]  pc,
   output logic             out_valid,
   output logic             out_taken,
   output logic [PC_W-1:0]  out_next_pc,
   output logic             out_call,
   output logic             out_exit,
   output logic             out_illegal
);
   if (XLEN < IMM_W) begin : g_bad_xlen
      initial $fatal(1, "br_eval_unit: XLEN must be at least IMM_W");
   end
   if (IMM_W < OFF_W) begin : g_bad_off
      initial $fatal(1, "br_eval_unit: IMM_W must be at least OFF_W");
   end
   if (PC_W < 2) begin : g_bad_pc
      initial $fatal(1, "br_eval_unit: PC_W too small");
   end

   logic [XLEN-1:0]  rhs;
   logic             hit;
   logic             is_call;
   logic [IMM_W-1:0] disp;
   logic [PC_W-1:0]  seq_pc, jmp_pc;
   logic             exit_ok;

   assign rhs     = src_sel ? src_val : XLEN'($signed(imm));
   assign is_call = (op_code == BR_CALL);
   assign disp    = is_call ? imm : IMM_W'($signed(offset));

   br_cmp #(.XLEN(XLEN)) u_cmp (
      .op (op_code), .lhs(dst_val), .rhs(rhs), .hit(hit)
   );

   br_target #(.PC_W(PC_W), .DISP_W(IMM_W)) u_tgt (
      .pc(pc), .disp(disp), .seq_pc(seq_pc), .jmp_pc(jmp_pc)
   );

   if (STRICT_EXIT) begin : g_exit_strict
      assign exit_ok = !src_sel && (regs == '0) && (offset == '0) && (imm == '0);
   end else begin : g_exit_loose
      assign exit_ok = 1'b1;
   end

   logic            d_taken, d_call, d_exit, d_ill;
   logic [PC_W-1:0] d_npc;

   always_comb begin
      d_taken = 1'b0;
      d_call  = 1'b0;
      d_exit  = 1'b0;
      d_ill   = 1'b0;
      unique case (br_op_e'(op_code))
         BR_ALWAYS: d_taken = 1'b1;
         BR_CALL: begin
            d_taken = 1'b1;
            d_call  = 1'b1;
         end
         BR_EXIT: begin
            d_exit = exit_ok;
            d_ill  = !exit_ok;
         end
         BR_BADE, BR_BADF: d_ill = 1'b1;
         default: d_taken = hit;
      endcase
      d_npc = d_taken ? jmp_pc : seq_pc;
      if (!in_valid) begin
         d_taken = 1'b0;
         d_call  = 1'b0;
         d_exit  = 1'b0;
         d_ill   = 1'b0;
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid   <= 1'b0;
            out_taken   <= 1'b0;
            out_next_pc <= '0;
            out_call    <= 1'b0;
            out_exit    <= 1'b0;
            out_illegal <= 1'b0;
         end else begin
            out_valid   <= in_valid;
            out_taken   <= d_taken;
            out_next_pc <= d_npc;
            out_call    <= d_call;
            out_exit    <= d_exit;
            out_illegal <= d_ill;
         end
      end
   end else begin : g_comb
      assign out_valid   = in_valid && rst_n;
      assign out_taken   = d_taken && rst_n;
      assign out_next_pc = d_npc;
      assign out_call    = d_call && rst_n;
      assign out_exit    = d_exit && rst_n;
      assign out_illegal = d_ill && rst_n;
   end
endmodule

// File: rtl/br_eval_chk.sv
module br_eval_chk #(
   parameter int XLEN    = 64,
   parameter int IMM_W   = 32,
   parameter int OFF_W   = 16,
   parameter int PC_W    = 32,
   parameter bit REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [3:0]       op_code,
   input logic [OFF_W-1:0] offset,
   input logic [PC_W-1:0]  pc,
   input logic             out_valid,
   input logic             out_taken,
   input logic [PC_W-1:0]  out_next_pc,
   input logic             out_call,
   input logic             out_exit,
   input logic             out_illegal
);
   // R10
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> (!out_taken && !out_call && !out_exit));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_taken && !out_call && !out_exit && !out_illegal));

   // R8
   call_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_call |-> out_taken);

   // R9
   exit_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_exit |-> !out_taken);

   if (REG_OUT) begin : g_reg_props
      // R11
      latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);

      // R10
      bad_op_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op_code[3:1] == 3'b111) |=>
            (out_illegal && out_next_pc == $past(pc) + PC_W'(1)));

      // R6
      always_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op_code == 4'h0) |=>
            (out_taken && out_next_pc ==
               $past(pc) + PC_W'(1) + PC_W'($signed($past(offset)))));
   end
endmodule

bind br_eval_unit br_eval_chk #(
   .XLEN(XLEN), .IMM_W(IMM_W), .OFF_W(OFF_W), .PC_W(PC_W), .REG_OUT(REG_OUT)
) u_br_eval_chk (.*);

// File: tb/tb_br_eval_unit.sv
module tb_br_eval_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  op_code = '0;
   logic        src_sel = 1'b0;
   logic [63:0] dst_val = '0;
   logic [63:0] src_val = '0;
   logic [31:0] imm = '0;
   logic [15:0] offset = '0;
   logic [7:0]  regs = '0;
   logic [31:0] pc = '0;
   logic        out_valid, out_taken, out_call, out_exit, out_illegal;
   logic [31:0] out_next_pc;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   br_eval_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
      .src_sel(src_sel), .dst_val(dst_val), .src_val(src_val), .imm(imm),
      .offset(offset), .regs(regs), .pc(pc), .out_valid(out_valid),
      .out_taken(out_taken), .out_next_pc(out_next_pc), .out_call(out_call),
      .out_exit(out_exit), .out_illegal(out_illegal)
   );

   typedef struct {
      bit          tk;
      logic [31:0] npc;
      bit          cl;
      bit          ex;
      bit          il;
      string       tag;
   } exp_t;

   exp_t expq[$];

   function automatic string def_tag(input logic [3:0] op);
      case (op)
         4'h0: return "R6";
         4'h1, 4'h5: return "R2";
         4'h2, 4'h3, 4'hA, 4'hB: return "R3";
         4'h6, 4'h7, 4'hC, 4'hD: return "R4";
         4'h4: return "R5";
         4'h8: return "R8";
         4'h9: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic send(input logic [3:0] op, input logic ss,
                       input logic [63:0] d, input logic [63:0] s,
                       input logic [31:0] im, input logic [15:0] of,
                       input logic [7:0] rg, input logic [31:0] p,
                       input string tag);
      exp_t e;
      logic [63:0] b;
      logic [31:0] disp;
      b = ss ? s : {{32{im[31]}}, im};
      e.tk = 0; e.cl = 0; e.ex = 0; e.il = 0;
      disp = {{16{of[15]}}, of};
      case (op)
         4'h0: e.tk = 1;
         4'h1: e.tk = (d == b);
         4'h5: e.tk = (d != b);
         4'h2: e.tk = (d > b);
         4'h3: e.tk = (d >= b);
         4'hA: e.tk = (d < b);
         4'hB: e.tk = (d <= b);
         4'h6: e.tk = ($signed(d) > $signed(b));
         4'h7: e.tk = ($signed(d) >= $signed(b));
         4'hC: e.tk = ($signed(d) < $signed(b));
         4'hD: e.tk = ($signed(d) <= $signed(b));
         4'h4: e.tk = ((d & b) != 0);
         4'h8: begin e.tk = 1; e.cl = 1; disp = im; end
         4'h9: begin
            if (!ss && rg == 0 && of == 0 && im == 0) e.ex = 1;
            else e.il = 1;
         end
         default: e.il = 1;
      endcase
      e.npc = e.tk ? (p + 32'd1 + disp) : (p + 32'd1);
      e.tag = (tag == "") ? def_tag(op) : tag;
      @(negedge clk);
      in_valid = 1; op_code = op; src_sel = ss; dst_val = d; src_val = s;
      imm = im; offset = of; regs = rg; pc = p;
      expq.push_back(e);
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         n_chk++;
         if (expq.size() == 0) begin
            n_fail++;
            $display("FAIL R11: unexpected out_valid, actual 1 expected 0");
         end else begin
            exp_t e;
            e = expq.pop_front();
            if (out_taken !== e.tk || out_next_pc !== e.npc || out_call !== e.cl ||
                out_exit !== e.ex || out_illegal !== e.il) begin
               n_fail++;
               $display("FAIL %s: actual tk=%0b npc=%h cl=%0b ex=%0b il=%0b expected tk=%0b npc=%h cl=%0b ex=%0b il=%0b",
                        e.tag, out_taken, out_next_pc, out_call, out_exit, out_illegal,
                        e.tk, e.npc, e.cl, e.ex, e.il);
            end
         end
      end
   end

   task automatic quiet_check(input string tag);
      n_chk++;
      if (out_valid !== 0 || out_taken !== 0 || out_call !== 0 ||
          out_exit !== 0 || out_illegal !== 0) begin
         n_fail++;
         $display("FAIL %s: actual v=%0b tk=%0b cl=%0b ex=%0b il=%0b expected all 0",
                  tag, out_valid, out_taken, out_call, out_exit, out_illegal);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [63:0] dv [6];
      logic [63:0] sv [6];
      dv[0] = 64'd5;                  sv[0] = 64'd5;
      dv[1] = 64'hFFFF_FFFF_FFFF_FFFF; sv[1] = 64'd1;
      dv[2] = 64'd1;                  sv[2] = 64'hFFFF_FFFF_FFFF_FFFF;
      dv[3] = 64'h8000_0000_0000_0000; sv[3] = 64'h7FFF_FFFF_FFFF_FFFF;
      dv[4] = 64'h0F;                 sv[4] = 64'hF0;
      dv[5] = 64'h3;                  sv[5] = 64'h2;

      repeat (3) @(negedge clk);
      // R12: outputs quiet in reset
      quiet_check("R12");
      rst_n = 1;
      @(negedge clk);
      quiet_check("R12");

      // Sweep all codes with register comparand; exits here are malformed (R9)
      for (int op = 0; op < 16; op++) begin
         for (int k = 0; k < 6; k++) begin
            send(4'(op), 1'b1, dv[k], sv[k], 32'(k * 100 - 150),
                 16'(k * 3 - 7), 8'h21, 32'(1000 + op * 16 + k), "");
         end
      end

      // R1: immediate sign-extended; src_val ignored
      send(4'h1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 32'hFFFF_FFFF, 16'd4, 8'h0, 32'd50, "R1");
      send(4'h1, 1'b0, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF, 32'h7FFF_FFFF, 16'd4, 8'h0, 32'd50, "R1");
      send(4'h1, 1'b0, 64'hFFFF_FFFF_7FFF_FFFF, 64'hFFFF_FFFF_7FFF_FFFF, 32'h7FFF_FFFF, 16'd4, 8'h0, 32'd50, "R1");
      send(4'h2, 1'b0, 64'd5, 64'd0, 32'hFFFF_FFFF, 16'd2, 8'h0, 32'd60, "R1");
      send(4'h6, 1'b0, 64'd5, 64'd0, 32'hFFFF_FFFF, 16'd2, 8'h0, 32'd60, "R1");
      // R7: wraparound and negative offset
      send(4'h0, 1'b0, 64'd0, 64'd0, 32'd0, 16'd1, 8'h0, 32'hFFFF_FFFF, "R7");
      send(4'h0, 1'b0, 64'd0, 64'd0, 32'd0, 16'h8000, 8'h0, 32'd10, "R7");
      send(4'h5, 1'b1, 64'd1, 64'd1, 32'd0, 16'h7FFF, 8'h0, 32'd20, "R7");
      // R8: call with negative and positive imm, offset ignored
      send(4'h8, 1'b0, 64'd9, 64'd3, 32'hFFFF_FFFB, 16'd77, 8'h0, 32'd100, "R8");
      send(4'h8, 1'b1, 64'd0, 64'd0, 32'h0001_0000, 16'h0, 8'h0, 32'd100, "R8");
      // R9: well-formed exit and single-field malformed exits
      send(4'h9, 1'b0, 64'd7, 64'd8, 32'd0, 16'd0, 8'h00, 32'd300, "R9");
      send(4'h9, 1'b1, 64'd7, 64'd8, 32'd0, 16'd0, 8'h00, 32'd300, "R9");
      send(4'h9, 1'b0, 64'd7, 64'd8, 32'd1, 16'd0, 8'h00, 32'd300, "R9");
      send(4'h9, 1'b0, 64'd7, 64'd8, 32'd0, 16'd0, 8'h10, 32'd300, "R9");
      // R10
      send(4'hE, 1'b0, 64'd0, 64'd0, 32'd0, 16'd5, 8'h0, 32'd400, "R10");
      send(4'hF, 1'b1, 64'd1, 64'd1, 32'd0, 16'd5, 8'h0, 32'd400, "R10");

      @(negedge clk);
      in_valid = 0;
      op_code = 4'h0;
      @(negedge clk);
      @(negedge clk);
      // R11: idle outputs quiet, every item produced
      quiet_check("R11");
      n_chk++;
      if (expq.size() != 0) begin
         n_fail++;
         $display("FAIL R11: actual %0d pending results expected 0", expq.size());
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule